// File: doc/BRIEF.md
# Control Transfer Stage Sequencer

This block follows the stages of control transfers on endpoint 0 of a full-speed device controller. Upstream packet logic hands it one-cycle events: a correctly received SETUP packet together with its eight request bytes, IN and OUT tokens addressed to endpoint 0, and the completion of a status-stage handshake. From these events the sequencer keeps a 3-bit stage code. The stage code tells firmware whether the transfer is in a read data stage, a write data stage, a status stage, or a sequence error.

On every SETUP the block stores the request as four 16-bit words and sets a setup-seen flag. The direction bit and the length field of the request choose the read, write or no-data path. Stage changes set five sticky cause flags. Four of these causes are maskable and one is always enabled, and together they drive a single interrupt line. For bring-up, a software mode lets the CPU force the stage code directly.

Top module: `ctl_stage_seq`

## Requirements
- R1: After reset, stage is 000, all cause flags, setup_seen and irq are 0, and req_words is all zero.
- R2: On setup_evt, req_words takes setup_data one cycle later. Byte k of the request is setup_data[8k+7:8k], so word 0 = {request code byte, type byte}, word 1 = value, word 2 = index and word 3 = length.
- R3: The stage after a SETUP depends on the type byte's bit 7 (setup_data[7]) and on the length word (setup_data[63:48]). Bit 7 = 1 gives 001 (read data). Bit 7 = 0 with a nonzero length gives 011 (write data). Bit 7 = 0 with a zero length gives 101 (no-data status).
- R4: Read path. In stage 001, out_tok moves the stage to 010 and sets cause_flags[2]. In stage 010, hs_done moves the stage to 000 and sets cause_flags[3].
- R5: Write path. In stage 011, in_tok moves the stage to 100 and sets cause_flags[1]. Entering 101 from a SETUP also sets cause_flags[1]. In stage 100 or 101, hs_done moves the stage to 000 and sets cause_flags[3]. hs_done has no effect in data stages.
- R6: A token whose direction does not match the current stage moves the stage to 110 and sets cause_flags[4]. The mismatching tokens are any token in 000, in_tok in 010, and out_tok in 100 or 101. A token matching the stage leaves the stage unchanged. In 110, tokens and hs_done are ignored.
- R7: A SETUP restarts the sequence from any stage, including 110, and sets cause_flags[0]. It takes priority over every other input in the same cycle.
- R8: irq = cause_flags[0] OR (cause_flags[4:1] AND int_en[3:0]), with int_en[0] enabling cause 1 up to int_en[3] enabling cause 4. A flag is set whatever its enable bit is.
- R9: Each cause flag stays set until the matching bit of cause_clr is pulsed. A set and a clear of the same flag in one cycle leave the flag set.
- R10: setup_seen is set on every SETUP and cleared by seen_clr, with a SETUP taking priority. setup_seen does not affect irq.
- R11: When sw_mode is 1, sw_stage_we loads sw_stage into the stage, except for the value 111, which is ignored. Software writes set no cause flag. sw_stage_we has no effect when sw_mode is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| setup_evt | input | 1 | Pulse: SETUP packet received without error |
| setup_data | input | 64 | Eight request bytes, byte 0 in the low bits |
| in_tok | input | 1 | Pulse: IN token for endpoint 0 |
| out_tok | input | 1 | Pulse: OUT token for endpoint 0 |
| hs_done | input | 1 | Pulse: status-stage handshake completed |
| sw_mode | input | 1 | Software override mode |
| sw_stage_we | input | 1 | Pulse: write sw_stage into the stage |
| sw_stage | input | 3 | Stage value written by software |
| int_en | input | 4 | Enables for cause flags 1 to 4 |
| cause_clr | input | 5 | Pulse per bit: clear cause flag |
| seen_clr | input | 1 | Pulse: clear setup_seen |
| stage | output | 3 | Current stage code |
| req_words | output | 64 | Captured request, four 16-bit words |
| setup_seen | output | 1 | SETUP received flag |
| cause_flags | output | 5 | Sticky stage-transition causes |
| irq | output | 1 | Stage-transition interrupt |

## Verification
A read request with a nonzero length, a write request with a nonzero length, and a write request with zero length are each walked through their full token sequence. These three runs tell apart the three SETUP branches and the two kinds of status-stage entry. Matching tokens, mismatching tokens, tokens in idle, and tokens and handshakes after an error separate a held stage from a sequence error. Same-cycle collisions of a SETUP with a token and with clear strobes show the input priority. Software writes with the mode off, with the reserved code, and with a legal code separate the override path from the hardware path.

// File: rtl/ctl_stage_pkg.sv
package ctl_stage_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'b000,
    ST_RD_DATA = 3'b001,
    ST_RD_STAT = 3'b010,
    ST_WR_DATA = 3'b011,
    ST_WR_STAT = 3'b100,
    ST_ND_STAT = 3'b101,
    ST_SEQ_ERR = 3'b110,
    ST_UNUSED  = 3'b111
  } stage_e;

  localparam int NCAUSE    = 5;
  localparam int CI_SETUP  = 0;
  localparam int CI_WSTAT  = 1;
  localparam int CI_RSTAT  = 2;
  localparam int CI_END    = 3;
  localparam int CI_SEQERR = 4;
endpackage

// File: rtl/ctl_req_capture.sv
module ctl_req_capture #(
  parameter int WORD_W = 16,
  parameter int NWORDS = 4,
  localparam int REQ_W = WORD_W * NWORDS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [REQ_W-1:0] cap_data,
  input  logic             seen_clr,
  output logic [REQ_W-1:0] words,
  output logic             seen
);
  genvar gi;
  generate
    for (gi = 0; gi < NWORDS; gi++) begin : g_word
      logic [WORD_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          word_q <= '0;
        end else if (cap_en) begin
          word_q <= cap_data[gi*WORD_W +: WORD_W];
        end
      end
      assign words[gi*WORD_W +: WORD_W] = word_q;
    end
  endgenerate

  logic seen_d;
  always_comb begin
    seen_d = seen;
    if (seen_clr) seen_d = 1'b0;
    if (cap_en)   seen_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= seen_d;
  end
endmodule

// File: rtl/ctl_stage_fsm.sv
module ctl_stage_fsm
  import ctl_stage_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              setup_evt,
  input  logic              dir_rd,
  input  logic              len_nz,
  input  logic              in_tok,
  input  logic              out_tok,
  input  logic              hs_done,
  input  logic              sw_we,
  input  logic [2:0]        sw_stage,
  output stage_e            stage,
  output logic [NCAUSE-1:0] cause_set
);
  stage_e nxt;

  always_comb begin
    nxt       = stage;
    cause_set = '0;
    if (setup_evt) begin
      cause_set[CI_SETUP] = 1'b1;
      if (dir_rd) begin
        nxt = ST_RD_DATA;
      end else if (len_nz) begin
        nxt = ST_WR_DATA;
      end else begin
        nxt = ST_ND_STAT;
        cause_set[CI_WSTAT] = 1'b1;
      end
    end else if (sw_we) begin
      if (sw_stage != 3'b111) nxt = stage_e'(sw_stage);
    end else begin
      case (stage)
        ST_IDLE: begin
          if (in_tok || out_tok) begin
            nxt = ST_SEQ_ERR;
            cause_set[CI_SEQERR] = 1'b1;
          end
        end
        ST_RD_DATA: begin
          if (out_tok) begin
            nxt = ST_RD_STAT;
            cause_set[CI_RSTAT] = 1'b1;
          end
        end
        ST_RD_STAT: begin
          if (in_tok) begin
            nxt = ST_SEQ_ERR;
            cause_set[CI_SEQERR] = 1'b1;
          end else if (hs_done) begin
            nxt = ST_IDLE;
            cause_set[CI_END] = 1'b1;
          end
        end
        ST_WR_DATA: begin
          if (in_tok) begin
            nxt = ST_WR_STAT;
            cause_set[CI_WSTAT] = 1'b1;
          end
        end
        ST_WR_STAT, ST_ND_STAT: begin
          if (out_tok) begin
            nxt = ST_SEQ_ERR;
            cause_set[CI_SEQERR] = 1'b1;
          end else if (hs_done) begin
            nxt = ST_IDLE;
            cause_set[CI_END] = 1'b1;
          end
        end
        ST_SEQ_ERR: nxt = ST_SEQ_ERR;
        default:    nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage <= ST_IDLE;
    else        stage <= nxt;
  end
endmodule

// File: rtl/ctl_cause_regs.sv
module ctl_cause_regs
  import ctl_stage_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCAUSE-1:0] cause_set,
  input  logic [NCAUSE-1:0] cause_clr,
  input  logic [NCAUSE-2:0] int_en,
  output logic [NCAUSE-1:0] flags,
  output logic              irq
);
  logic [NCAUSE-1:0] en_full;
  assign en_full = {int_en, 1'b1};

  genvar gi;
  generate
    for (gi = 0; gi < NCAUSE; gi++) begin : g_flag
      logic flag_d;
      always_comb begin
        flag_d = flags[gi];
        if (cause_clr[gi]) flag_d = 1'b0;
        if (cause_set[gi]) flag_d = 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags[gi] <= 1'b0;
        else        flags[gi] <= flag_d;
      end
    end
  endgenerate

  assign irq = |(flags & en_full);
endmodule

// File: rtl/ctl_stage_seq.sv
module ctl_stage_seq
  import ctl_stage_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int NWORDS  = 4,
  parameter int DIR_BIT = 7,
  localparam int REQ_W  = WORD_W * NWORDS,
  localparam int LEN_LO = WORD_W * (NWORDS - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              setup_evt,
  input  logic [REQ_W-1:0]  setup_data,
  input  logic              in_tok,
  input  logic              out_tok,
  input  logic              hs_done,
  input  logic              sw_mode,
  input  logic              sw_stage_we,
  input  logic [2:0]        sw_stage,
  input  logic [NCAUSE-2:0] int_en,
  input  logic [NCAUSE-1:0] cause_clr,
  input  logic              seen_clr,
  output logic [2:0]        stage,
  output logic [REQ_W-1:0]  req_words,
  output logic              setup_seen,
  output logic [NCAUSE-1:0] cause_flags,
  output logic              irq
);
  stage_e            stage_q;
  logic [NCAUSE-1:0] cause_set;
  logic              sw_we;
  logic              dir_rd;
  logic              len_nz;

  assign sw_we  = sw_mode & sw_stage_we;
  assign dir_rd = setup_data[DIR_BIT];
  assign len_nz = |setup_data[LEN_LO +: WORD_W];

  ctl_req_capture #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (setup_evt),
    .cap_data (setup_data),
    .seen_clr (seen_clr),
    .words    (req_words),
    .seen     (setup_seen)
  );

  ctl_stage_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .setup_evt (setup_evt),
    .dir_rd    (dir_rd),
    .len_nz    (len_nz),
    .in_tok    (in_tok),
    .out_tok   (out_tok),
    .hs_done   (hs_done),
    .sw_we     (sw_we),
    .sw_stage  (sw_stage),
    .stage     (stage_q),
    .cause_set (cause_set)
  );

  ctl_cause_regs u_cause (
    .clk       (clk),
    .rst_n     (rst_n),
    .cause_set (cause_set),
    .cause_clr (cause_clr),
    .int_en    (int_en),
    .flags     (cause_flags),
    .irq       (irq)
  );

  assign stage = stage_q;
endmodule

// File: rtl/ctl_stage_seq_chk.sv
module ctl_stage_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        setup_evt,
  input logic [63:0] setup_data,
  input logic        in_tok,
  input logic        out_tok,
  input logic        hs_done,
  input logic        sw_mode,
  input logic        sw_stage_we,
  input logic [2:0]  stage,
  input logic [63:0] req_words,
  input logic        setup_seen,
  input logic [4:0]  cause_flags,
  input logic        irq
);
  p_no_unused_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stage != 3'b111);

  p_setup_path_r3: assert property (@(posedge clk) disable iff (!rst_n)
    setup_evt |=> (stage == 3'b001 || stage == 3'b011 || stage == 3'b101));

  p_setup_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    setup_evt |=> (cause_flags[0] && setup_seen));

  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    setup_evt |=> (req_words == $past(setup_data)));

  p_setup_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cause_flags[0] |-> irq);

  p_stage_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!setup_evt && !(sw_mode && sw_stage_we) && !in_tok && !out_tok && !hs_done)
      |=> $stable(stage));

  p_err_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!setup_evt && !(sw_mode && sw_stage_we) && stage == 3'b000 && (in_tok || out_tok))
      |=> (stage == 3'b110 && cause_flags[4]));
endmodule

bind ctl_stage_seq ctl_stage_seq_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .setup_evt   (setup_evt),
  .setup_data  (setup_data),
  .in_tok      (in_tok),
  .out_tok     (out_tok),
  .hs_done     (hs_done),
  .sw_mode     (sw_mode),
  .sw_stage_we (sw_stage_we),
  .stage       (stage),
  .req_words   (req_words),
  .setup_seen  (setup_seen),
  .cause_flags (cause_flags),
  .irq         (irq)
);

// File: tb/ctl_stage_seq_tb_top.sv
`timescale 1ns/1ps
module ctl_stage_seq_tb_top;
  logic        clk;
  logic        rst_n;
  logic        setup_evt;
  logic [63:0] setup_data;
  logic        in_tok;
  logic        out_tok;
  logic        hs_done;
  logic        sw_mode;
  logic        sw_stage_we;
  logic [2:0]  sw_stage;
  logic [3:0]  int_en;
  logic [4:0]  cause_clr;
  logic        seen_clr;
  logic [2:0]  stage;
  logic [63:0] req_words;
  logic        setup_seen;
  logic [4:0]  cause_flags;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  ctl_stage_seq dut_i (
    .clk(clk), .rst_n(rst_n), .setup_evt(setup_evt), .setup_data(setup_data),
    .in_tok(in_tok), .out_tok(out_tok), .hs_done(hs_done), .sw_mode(sw_mode),
    .sw_stage_we(sw_stage_we), .sw_stage(sw_stage), .int_en(int_en),
    .cause_clr(cause_clr), .seen_clr(seen_clr), .stage(stage),
    .req_words(req_words), .setup_seen(setup_seen), .cause_flags(cause_flags),
    .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_req(logic [7:0] rtype, logic [7:0] code,
                                        logic [15:0] val, logic [15:0] idx,
                                        logic [15:0] len);
    return {len, idx, val, code, rtype};
  endfunction

  task automatic idle_all();
    setup_evt = 0; in_tok = 0; out_tok = 0; hs_done = 0;
    sw_stage_we = 0; cause_clr = '0; seen_clr = 0;
  endtask

  task automatic do_setup(logic [63:0] d);
    @(negedge clk); setup_evt = 1; setup_data = d;
    @(negedge clk); idle_all();
  endtask

  task automatic do_in();
    @(negedge clk); in_tok = 1;
    @(negedge clk); idle_all();
  endtask

  task automatic do_out();
    @(negedge clk); out_tok = 1;
    @(negedge clk); idle_all();
  endtask

  task automatic do_hs();
    @(negedge clk); hs_done = 1;
    @(negedge clk); idle_all();
  endtask

  task automatic clr_all();
    @(negedge clk); cause_clr = 5'h1f;
    @(negedge clk); idle_all();
  endtask

  task automatic t_reset();
    chk("R1", "stage", stage, 0);
    chk("R1", "flags", cause_flags, 0);
    chk("R1", "seen", setup_seen, 0);
    chk("R1", "irq", irq, 0);
    chk("R1", "words", req_words, 0);
  endtask

  task automatic t_read();
    logic [63:0] d;
    d = mk_req(8'h80, 8'h06, 16'h0100, 16'h0000, 16'h0012);
    do_setup(d);
    chk("R2", "word0", req_words[15:0], 16'h0680);
    chk("R2", "word1", req_words[31:16], 16'h0100);
    chk("R2", "word3", req_words[63:48], 16'h0012);
    chk("R3", "read stage", stage, 3'b001);
    chk("R7", "setup cause", cause_flags, 5'b00001);
    chk("R8", "setup irq", irq, 1);
    chk("R10", "seen", setup_seen, 1);
    clr_all();
    chk("R9", "cleared", cause_flags, 0);
    do_in();
    chk("R6", "matching IN holds", stage, 3'b001);
    do_out();
    chk("R4", "read status", stage, 3'b010);
    chk("R4", "read cause", cause_flags, 5'b00100);
    chk("R8", "masked irq", irq, 0);
    @(negedge clk); int_en = 4'b0010;
    #1 chk("R8", "enabled irq", irq, 1);
    do_out();
    chk("R6", "status OUT holds", stage, 3'b010);
    do_hs();
    chk("R4", "end stage", stage, 3'b000);
    chk("R9", "sticky + end", cause_flags, 5'b01100);
    int_en = 0;
    clr_all();
  endtask

  task automatic t_write();
    do_setup(mk_req(8'h00, 8'h09, 16'h0001, 16'h0000, 16'h0004));
    chk("R3", "write stage", stage, 3'b011);
    clr_all();
    do_hs();
    chk("R5", "hs in data ignored", stage, 3'b011);
    do_out();
    chk("R6", "matching OUT holds", stage, 3'b011);
    do_in();
    chk("R5", "write status", stage, 3'b100);
    chk("R5", "wstat cause", cause_flags, 5'b00010);
    do_out();
    chk("R6", "mismatch to err", stage, 3'b110);
    chk("R6", "err cause", cause_flags, 5'b10010);
    do_in();
    do_hs();
    chk("R6", "err holds", stage, 3'b110);
    clr_all();
    do_setup(mk_req(8'h00, 8'h05, 16'h0007, 16'h0000, 16'h0000));
    chk("R7", "restart from err", stage, 3'b101);
    chk("R5", "nodata causes", cause_flags, 5'b00011);
    do_hs();
    chk("R5", "nodata end", stage, 3'b000);
    chk("R5", "end cause", cause_flags[3], 1);
    clr_all();
  endtask

  task automatic t_idle_tok();
    do_out();
    chk("R6", "idle token err", stage, 3'b110);
    chk("R6", "idle err cause", cause_flags, 5'b10000);
    @(negedge clk);
    setup_evt = 1; setup_data = mk_req(8'hC0, 8'h01, 0, 0, 16'h0002);
    in_tok = 1; cause_clr = 5'h1f;
    @(negedge clk); idle_all();
    chk("R7", "setup priority stage", stage, 3'b001);
    chk("R9", "set beats clear", cause_flags, 5'b00001);
    clr_all();
  endtask

  task automatic t_seen();
    @(negedge clk); seen_clr = 1;
    @(negedge clk); idle_all();
    chk("R10", "seen cleared", setup_seen, 0);
    chk("R10", "irq unaffected", irq, 0);
    @(negedge clk); seen_clr = 1; setup_evt = 1;
    setup_data = mk_req(8'h80, 8'h00, 0, 0, 16'h0002);
    @(negedge clk); idle_all();
    chk("R10", "setup beats clear", setup_seen, 1);
    clr_all();
  endtask

  task automatic t_sw();
    chk("R11", "start stage", stage, 3'b001);
    @(negedge clk); sw_mode = 0; sw_stage_we = 1; sw_stage = 3'b011;
    @(negedge clk); idle_all();
    chk("R11", "mode off ignored", stage, 3'b001);
    @(negedge clk); sw_mode = 1; sw_stage_we = 1; sw_stage = 3'b011;
    @(negedge clk); idle_all();
    chk("R11", "sw write", stage, 3'b011);
    chk("R11", "no cause", cause_flags, 0);
    @(negedge clk); sw_stage_we = 1; sw_stage = 3'b111;
    @(negedge clk); idle_all();
    chk("R11", "111 ignored", stage, 3'b011);
    sw_mode = 0;
  endtask

  initial begin
    idle_all();
    setup_data = '0; sw_mode = 0; sw_stage = 0; int_en = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_read();
    t_write();
    t_idle_tok();
    t_seen();
    t_sw();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule